// File: doc/BRIEF.md
# FIFO Level-Transition Interrupt Generator

This block watches the fill status of a group of transmit FIFOs and a group of receive FIFOs, and raises one interrupt per direction. A transmit link counts only once it has been completely full and has then drained to completely empty. Each transmit link therefore keeps its own remembered "has been full" flag. A receive link counts whenever its FIFO moves from empty to holding a word. All links of one direction are merged into a single interrupt pulse.

The FIFOs drive the status inputs directly: per-link full and empty flags, and a per-link enable. A global enable gates everything. While the global enable is clear, no interrupt is raised and all remembered history is dropped. The same happens for a link that is switched off or not built. Links whose index is at or above the built count (`NUM_TX`, `NUM_RX`) are ignored entirely. Both outputs are plain one-clock pulses. There is no data path, so no valid/ready handshake exists at the block's edge.

Top module: `level_irq_gen`

## Requirements
- R1: When an active TX link whose full history is set reports empty in cycle t, `tx_irq` is high in cycle t+1 for exactly that cycle.
- R2: An empty TX link with no full history does not raise `tx_irq`. Partial fill levels between full and empty keep the history.
- R3: When an active RX link reported empty in cycle t-1 (while active) and not empty in cycle t, `rx_irq` is high in cycle t+1.
- R4: While `enable` is low, neither output is raised, and all history is cleared. A TX link that was full before disabling does not fire on re-enable. An RX word that arrived while disabled does not fire.
- R5: A link whose enable bit is low, or whose index (bit position i of the per-link ports is link i) is at or above the built count, never contributes, and its history is cleared.
- R6: Several links qualifying in the same cycle give one single-cycle pulse, not a longer one.
- R7: Synchronous reset (`rst` high) holds both outputs low and clears all history.
- R8: A TX report clears that link's history. Staying empty afterwards raises no further pulse until the link is full again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Global enable |
| tx_link_en | input | 8 | Per-link enable, transmit side |
| tx_full | input | 8 | Per-link FIFO full flag, transmit side |
| tx_empty | input | 8 | Per-link FIFO empty flag, transmit side |
| rx_link_en | input | 8 | Per-link enable, receive side |
| rx_empty | input | 8 | Per-link FIFO empty flag, receive side |
| tx_irq | output | 1 | One-cycle pulse: a full TX FIFO has drained |
| rx_irq | output | 1 | One-cycle pulse: an empty RX FIFO received a word |

## Verification
The two detectors are independent, so a TX drain and an RX arrival can land in the same cycle. Two or more links of one direction can also qualify together. The stimulus table contains a cycle where two TX links that were both full drain together while two RX links receive words. The next cycle must then show exactly one pulse on each output, followed by silence. The judgement uses only the port values one edge after the stimulus.

// File: rtl/slirq_pkg.sv
package slirq_pkg;
  // Width of every per-link status port, independent of the built counts
  localparam int unsigned MAX_LINKS = 8;
endpackage

// File: rtl/tx_drain_tracker.sv
module tx_drain_tracker (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic full,
  input  logic empty,
  output logic drained
);
  logic was_full;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      was_full <= 1'b0;
    end else if (was_full && empty) begin
      was_full <= 1'b0;
    end else if (full) begin
      was_full <= 1'b1;
    end
  end

  assign drained = active & was_full & empty;

  // R5: an inactive cycle leaves no history for the next one
  p_history_dropped_r5: assert property (@(posedge clk) disable iff (rst)
    !active |=> !drained);

  // R8: a report consumes the history unless the FIFO refills at once
  p_single_report_r8: assert property (@(posedge clk) disable iff (rst)
    (drained && !full) |=> !drained);
endmodule

// File: rtl/rx_arrival_detector.sv
module rx_arrival_detector (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic empty,
  output logic arrived
);
  logic prev_empty;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      prev_empty <= 1'b0;
    end else begin
      prev_empty <= empty;
    end
  end

  assign arrived = active & prev_empty & ~empty;

  // R3: an arrival always follows a cycle in which the FIFO was empty
  p_arrival_after_empty_r3: assert property (@(posedge clk) disable iff (rst)
    arrived |-> $past(empty) && $past(active));
endmodule

// File: rtl/level_irq_gen.sv
module level_irq_gen
  import slirq_pkg::*;
#(
  parameter int unsigned NUM_TX = 8,
  parameter int unsigned NUM_RX = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic [MAX_LINKS-1:0] tx_link_en,
  input  logic [MAX_LINKS-1:0] tx_full,
  input  logic [MAX_LINKS-1:0] tx_empty,
  input  logic [MAX_LINKS-1:0] rx_link_en,
  input  logic [MAX_LINKS-1:0] rx_empty,
  output logic                 tx_irq,
  output logic                 rx_irq
);
  localparam int unsigned TX_BUILT = (NUM_TX > MAX_LINKS) ? MAX_LINKS : NUM_TX;
  localparam int unsigned RX_BUILT = (NUM_RX > MAX_LINKS) ? MAX_LINKS : NUM_RX;

  logic [MAX_LINKS-1:0] tx_drained;
  logic [MAX_LINKS-1:0] rx_arrived;

  for (genvar i = 0; i < MAX_LINKS; i++) begin : g_link
    if (i < TX_BUILT) begin : g_tx
      tx_drain_tracker u_tx (
        .clk     (clk),
        .rst     (rst),
        .active  (enable & tx_link_en[i]),
        .full    (tx_full[i]),
        .empty   (tx_empty[i]),
        .drained (tx_drained[i])
      );
    end else begin : g_tx_off
      assign tx_drained[i] = 1'b0;
    end

    if (i < RX_BUILT) begin : g_rx
      rx_arrival_detector u_rx (
        .clk     (clk),
        .rst     (rst),
        .active  (enable & rx_link_en[i]),
        .empty   (rx_empty[i]),
        .arrived (rx_arrived[i])
      );
    end else begin : g_rx_off
      assign rx_arrived[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_irq <= 1'b0;
      rx_irq <= 1'b0;
    end else begin
      tx_irq <= enable & (|tx_drained);
      rx_irq <= enable & (|rx_arrived);
    end
  end

  // R4: a disabled cycle is never followed by a pulse
  p_quiet_when_off_r4: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!tx_irq && !rx_irq));

  // R1: a TX pulse needs an enabled, empty, active link one cycle earlier
  p_tx_source_r1: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> ($past(enable) && $past(|(tx_empty & tx_link_en))));

  // R3: empty-to-filled on built link 0 yields an RX pulse
  p_rx_arrival_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(enable && rx_link_en[0] && rx_empty[0]) &&
     enable && rx_link_en[0] && !rx_empty[0]) |=> rx_irq);

  // R7: the cycle after reset shows no pulse
  p_reset_quiet_r7: assert property (@(posedge clk)
    rst |=> (!tx_irq && !rx_irq));
endmodule

// File: tb/level_irq_gen_tb.sv
module level_irq_gen_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic [7:0] tx_link_en, tx_full, tx_empty, rx_link_en, rx_empty;
  logic       tx_irq, rx_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  level_irq_gen #(.NUM_TX(6), .NUM_RX(5)) u_dut (
    .clk(clk), .rst(rst), .enable(enable),
    .tx_link_en(tx_link_en), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_link_en(rx_link_en), .rx_empty(rx_empty),
    .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // {en, tx_en, tx_full, tx_empty, rx_en, rx_empty, exp_tx, exp_rx}
  localparam int NV = 27;
  localparam logic [42:0] VEC [NV] = '{
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 0  R2 idle empty, no history
    {1'b1, 8'hFF, 8'h01, 8'hFE, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 1  R2 tx0 full
    {1'b1, 8'hFF, 8'h00, 8'hFE, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 2  R2 tx0 partial
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0}, // 3  R1 tx0 drained
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 4  R8 stays empty
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFE, 1'b0, 1'b1}, // 5  R3 rx0 word
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFE, 1'b0, 1'b0}, // 6  R3 still filled
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 7  R3 emptied again
    {1'b1, 8'hFF, 8'h02, 8'hFD, 8'hFF, 8'hFB, 1'b0, 1'b1}, // 8  R3 rx2 word, tx1 full
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b1, 1'b0}, // 9  R1 tx1 drained
    {1'b1, 8'hFF, 8'h0C, 8'hF3, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 10 R6 tx2,tx3 full
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFC, 1'b1, 1'b1}, // 11 R6 both sides, several links
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 12 R6 pulse is one cycle
    {1'b1, 8'hFF, 8'h80, 8'h7F, 8'hFF, 8'hBF, 1'b0, 1'b0}, // 13 R5 unbuilt tx7, rx6
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 14 R5 unbuilt tx7 drains
    {1'b1, 8'hFE, 8'h01, 8'hFE, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 15 R5 tx0 off while full
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 16 R5 tx0 on, no history
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFE, 8'hFE, 1'b0, 1'b0}, // 17 R5 rx0 off, word
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFE, 1'b0, 1'b0}, // 18 R5 rx0 on, no history
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 19 R5 settle
    {1'b1, 8'hFF, 8'h01, 8'hFE, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 20 R4 tx0 full
    {1'b0, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 21 R4 drains while off
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 22 R4 history gone
    {1'b1, 8'hFF, 8'h02, 8'hFD, 8'hFF, 8'hFF, 1'b0, 1'b0}, // 23 R4 tx1 full
    {1'b0, 8'hFF, 8'h02, 8'hFD, 8'hFF, 8'hFE, 1'b0, 1'b0}, // 24 R4 rx0 word while off
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFE, 1'b0, 1'b0}, // 25 R4 re-enable, no pulses
    {1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0}  // 26 R4 settle
  };

  function automatic string req_of(int row);
    if (row == 3 || row == 9)       return "R1";
    if (row <= 2)                   return "R2";
    if (row == 4)                   return "R8";
    if (row <= 8)                   return "R3";
    if (row <= 12)                  return "R6";
    if (row <= 19)                  return "R5";
    return "R4";
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic drive(logic en, logic [7:0] te, logic [7:0] tf, logic [7:0] tm,
                       logic [7:0] re, logic [7:0] rm);
    enable = en; tx_link_en = te; tx_full = tf; tx_empty = tm;
    rx_link_en = re; rx_empty = rm;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF);
    repeat (3) @(posedge clk);
    #1;
    check("R7", "tx_irq in reset", tx_irq, 1'b0);
    check("R7", "rx_irq in reset", rx_irq, 1'b0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][42], VEC[v][41:34], VEC[v][33:26], VEC[v][25:18],
            VEC[v][17:10], VEC[v][9:2]);
      @(posedge clk);
      #1;
      check(req_of(v), $sformatf("row %0d tx_irq", v), tx_irq, VEC[v][1]);
      check(req_of(v), $sformatf("row %0d rx_irq", v), rx_irq, VEC[v][0]);
    end

    // R7: reset drops TX history and RX history
    drive(1'b1, 8'hFF, 8'h01, 8'hFE, 8'hFF, 8'hFF);
    @(posedge clk); #1;
    rst = 1'b1;
    drive(1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFE);
    @(posedge clk); #1;
    check("R7", "tx_irq with reset held", tx_irq, 1'b0);
    check("R7", "rx_irq with reset held", rx_irq, 1'b0);
    rst = 1'b0;
    drive(1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFE);
    @(posedge clk); #1;
    check("R7", "tx_irq after reset", tx_irq, 1'b0);
    check("R7", "rx_irq after reset", rx_irq, 1'b0);

    // R1: refill after a report arms a second pulse
    drive(1'b1, 8'hFF, 8'h20, 8'hDF, 8'hFF, 8'hFF);
    @(posedge clk); #1;
    drive(1'b1, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hFF);
    @(posedge clk); #1;
    check("R1", "tx5 (last built) drained", tx_irq, 1'b1);
    @(posedge clk); #1;
    check("R1", "pulse ends", tx_irq, 1'b0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end
endmodule